// File: doc/BRIEF.md
# RTC Status Flag Register

This block keeps the sticky status flags of a real-time clock. Four event flags record an alarm match, a low main supply and two battery-low levels. Each flag is raised by a one-cycle event pulse from logic outside the block and stays raised until software clears it. A fifth flag, clock-fail, reports that the clock lost its time because the main supply and the battery were both gone at the same moment.

The bus side arrives as already-decoded strobes. One strobe marks a completed read of the status register that ended with a valid STOP. Another marks any byte written to the timekeeping registers. A plain register write path carries a select and a data byte. When the auto-clear control bit is set, a completed status read clears the four event flags. When it is clear, software clears them by writing zeros. Clock-fail can only be cleared by a write to the timekeeping registers. The supply-presence inputs are asynchronous and pass through a synchronizer inside the block.

Top module: `rtc_status_flags`

## Requirements
- R1: After reset the four event flags read 0, the auto-clear bit reads 0 and clock-fail reads 1.
- R2: A pulse on evt_i[i] sets flags_o[i] at the next clock edge. Bit 0 is the alarm, bit 1 is main-low, bit 2 is battery-high-threshold and bit 3 is battery-low-threshold.
- R3: An event flag stays at 1 while there is no status write and no auto-clearing read. A read without a valid STOP never produces a stat_rd_i pulse, so it leaves the flags unchanged.
- R4: With auto_clr_o at 1, a stat_rd_i pulse clears all four event flags at the next edge.
- R5: With auto_clr_o at 0, a stat_rd_i pulse has no effect on any flag.
- R6: An event pulse that arrives in the same cycle as a clearing read or a status write wins, and the flag ends at 1.
- R7: A register write with reg_sel_i = 0 treats reg_wdata_i[3:0] as a mask. A 0 bit clears the matching flag and a 1 bit leaves it as it is. The write never sets a flag and never touches clock-fail.
- R8: A register write with reg_sel_i = 1 loads auto_clr_o from reg_wdata_i[7]. No other event changes auto_clr_o.
- R9: Clock-fail is set within SYNC_STAGES + 2 cycles after either supply returns following a period when both supplies were absent at once. This holds whichever supply returns first.
- R10: Losing only one supply, while the other stays present, never sets clock-fail.
- R11: A rtc_wr_i pulse clears clock-fail. Status reads and status writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| main_ok_i | input | 1 | Main supply present (asynchronous) |
| bat_ok_i | input | 1 | Battery supply present (asynchronous) |
| evt_i | input | NFLAG | One-cycle set pulses, one per event flag |
| stat_rd_i | input | 1 | Status register read completed with a valid STOP |
| rtc_wr_i | input | 1 | A byte was written to the timekeeping registers |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Write target: 0 status mask, 1 control |
| reg_wdata_i | input | DATA_W | Write data |
| flags_o | output | NFLAG | Event flags |
| clk_fail_o | output | 1 | Clock-fail flag |
| auto_clr_o | output | 1 | Auto-clear control bit |

## Verification
The bench uses the default build: four flags, an 8-bit data path and a two-stage synchronizer. With four flags, every combination of starting pattern, write mask and simultaneous event pattern can be swept, and the same holds for every starting pattern and event pattern during a read in both auto-clear settings. This covers every priority case between set and clear on every bit. The supply tests drive each loss order and each return order directly and allow for the synchronizer latency.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_CTRL   = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/rsf_supply_mon.sv
module rsf_supply_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic main_ok_i,
    input  logic bat_ok_i,
    input  logic rtc_wr_i,
    output logic clk_fail_o
);
    localparam int SW = SYNC_STAGES;

    typedef struct packed {
        logic [SW-1:0] msh;
        logic [SW-1:0] bsh;
        logic          dead;
        logic          fail;
    } st_t;

    st_t  st_d, st_q;
    logic main_s, bat_s, both_off, restore;

    assign main_s   = st_q.msh[SW-1];
    assign bat_s    = st_q.bsh[SW-1];
    assign both_off = !main_s && !bat_s;
    assign restore  = st_q.dead && !both_off;

    always_comb begin
        st_d      = st_q;
        st_d.msh  = (st_q.msh << 1) | SW'(main_ok_i);
        st_d.bsh  = (st_q.bsh << 1) | SW'(bat_ok_i);
        st_d.dead = both_off;
        if (restore)       st_d.fail = 1'b1;
        else if (rtc_wr_i) st_d.fail = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.msh  <= '1;
            st_q.bsh  <= '1;
            st_q.dead <= 1'b0;
            st_q.fail <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_fail_o = st_q.fail;

    // R9 R10
    fail_needs_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.fail) |-> $past(st_q.dead));
    // R11
    fail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rtc_wr_i && !restore) |=> !st_q.fail);
    // R10
    dead_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (main_s || bat_s) |=> !st_q.dead);
endmodule

// File: rtl/rsf_flag_bank.sv
module rsf_flag_bank #(
    parameter int NFLAG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] evt_i,
    input  logic             clr_all_i,
    input  logic             mask_wr_i,
    input  logic [NFLAG-1:0] keep_i,
    output logic [NFLAG-1:0] flags_o
);
    logic [NFLAG-1:0] fl_d, fl_q;

    always_comb begin
        for (int i = 0; i < NFLAG; i++) begin
            fl_d[i] = fl_q[i];
            if (clr_all_i)              fl_d[i] = 1'b0;
            if (mask_wr_i && !keep_i[i]) fl_d[i] = 1'b0;
            if (evt_i[i])               fl_d[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign flags_o = fl_q;

    for (genvar g = 0; g < NFLAG; g++) begin : g_chk
        // R2 R6
        evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[g] |=> flags_o[g]);
        // R3
        sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_o[g] && !clr_all_i && !(mask_wr_i && !keep_i[g])) |=> flags_o[g]);
        // R4
        auto_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_all_i && !evt_i[g]) |=> !flags_o[g]);
        // R7
        no_spont_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!flags_o[g] && !evt_i[g]) |=> !flags_o[g]);
    end
endmodule

// File: rtl/rsf_ctrl_reg.sv
module rsf_ctrl_reg #(
    parameter int DATA_W   = 8,
    parameter int AUTO_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              auto_o
);
    logic auto_d, auto_q;

    always_comb begin
        auto_d = auto_q;
        if (wr_i) auto_d = wdata_i[AUTO_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) auto_q <= 1'b0;
        else        auto_q <= auto_d;
    end

    assign auto_o = auto_q;

    // R8
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(auto_q));
endmodule

// File: rtl/rtc_status_flags.sv
module rtc_status_flags #(
    parameter int NFLAG       = 4,
    parameter int DATA_W      = 8,
    parameter int AUTO_BIT    = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              main_ok_i,
    input  logic              bat_ok_i,
    input  logic [NFLAG-1:0]  evt_i,
    input  logic              stat_rd_i,
    input  logic              rtc_wr_i,
    input  logic              reg_wr_i,
    input  logic              reg_sel_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [NFLAG-1:0]  flags_o,
    output logic              clk_fail_o,
    output logic              auto_clr_o
);
    import rsf_pkg::*;

    logic stat_wr, ctrl_wr, clr_all;

    assign stat_wr = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_STATUS);
    assign ctrl_wr = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_CTRL);
    assign clr_all = stat_rd_i && auto_clr_o;

    rsf_ctrl_reg #(.DATA_W(DATA_W), .AUTO_BIT(AUTO_BIT)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ctrl_wr),
        .wdata_i (reg_wdata_i),
        .auto_o  (auto_clr_o)
    );

    rsf_flag_bank #(.NFLAG(NFLAG)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt_i),
        .clr_all_i (clr_all),
        .mask_wr_i (stat_wr),
        .keep_i    (reg_wdata_i[NFLAG-1:0]),
        .flags_o   (flags_o)
    );

    rsf_supply_mon #(.SYNC_STAGES(SYNC_STAGES)) u_supply (
        .clk        (clk),
        .rst_n      (rst_n),
        .main_ok_i  (main_ok_i),
        .bat_ok_i   (bat_ok_i),
        .rtc_wr_i   (rtc_wr_i),
        .clk_fail_o (clk_fail_o)
    );

    // R5
    no_auto_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_i && !auto_clr_o && !reg_wr_i && evt_i == '0) |=> $stable(flags_o));
    // R11
    fail_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_fail_o && !rtc_wr_i) |=> clk_fail_o);
endmodule

// File: tb/rtc_status_flags_tb.sv
module rtc_status_flags_tb;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       main_ok = 1, bat_ok = 1;
    logic [3:0] evt = 0;
    logic       stat_rd = 0, rtc_wr = 0, reg_wr = 0, reg_sel = 0;
    logic [7:0] wdata = 0;
    logic [3:0] flags;
    logic       clk_fail, auto_clr;
    int total = 0, bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rtc_status_flags u_dut (
        .clk(clk), .rst_n(rst_n), .main_ok_i(main_ok), .bat_ok_i(bat_ok),
        .evt_i(evt), .stat_rd_i(stat_rd), .rtc_wr_i(rtc_wr), .reg_wr_i(reg_wr),
        .reg_sel_i(reg_sel), .reg_wdata_i(wdata), .flags_o(flags),
        .clk_fail_o(clk_fail), .auto_clr_o(auto_clr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask

    task automatic idle();
        evt = 0; stat_rd = 0; rtc_wr = 0; reg_wr = 0; reg_sel = 0; wdata = 0;
    endtask

    task automatic set_auto(input bit a);
        reg_wr = 1; reg_sel = 1; wdata = {a, 7'h55}; tick(); idle();
    endtask

    task automatic load(input logic [3:0] p);
        reg_wr = 1; reg_sel = 0; wdata = 8'h00; tick(); idle();
        evt = p; tick(); idle();
    endtask

    task automatic wait_fail(input bit exp, input string req);
        for (int k = 0; k < 5; k++) tick();
        chk(clk_fail == exp, req, clk_fail, exp);
    endtask

    initial begin
        idle();
        tick(); tick();
        rst_n = 1;
        tick();
        // R1
        chk(flags == 0, "R1", flags, 0);
        chk(auto_clr == 0, "R1", auto_clr, 0);
        chk(clk_fail == 1, "R1", clk_fail, 1);

        // R2 single events
        for (int i = 0; i < 4; i++) begin
            load(4'(1 << i));
            chk(flags == 4'(1 << i), "R2", flags, 1 << i);
            for (int k = 0; k < 3; k++) tick();
            chk(flags == 4'(1 << i), "R3", flags, 1 << i);
        end

        // R8 control write and its hold
        set_auto(1);
        chk(auto_clr == 1, "R8", auto_clr, 1);
        reg_wr = 1; reg_sel = 0; wdata = 8'h0F; stat_rd = 0; tick(); idle();
        chk(auto_clr == 1, "R8", auto_clr, 1);

        // R4 R5 R6 sweep: pattern p, auto a, event e during read
        for (int a = 0; a < 2; a++) begin
            set_auto(a[0]);
            for (int p = 0; p < 16; p++) begin
                for (int e = 0; e < 16; e++) begin
                    load(4'(p));
                    stat_rd = 1; evt = 4'(e); tick(); idle();
                    if (a == 1) chk(flags == 4'(e), e != 0 ? "R6" : "R4", flags, e);
                    else        chk(flags == 4'(p | e), "R5", flags, p | e);
                end
            end
        end

        // R3: no read pulse (aborted read) with auto on
        set_auto(1);
        load(4'hF);
        for (int k = 0; k < 4; k++) tick();
        chk(flags == 4'hF, "R3", flags, 4'hF);

        // R7 R6 sweep: pattern, mask, event
        set_auto(0);
        for (int p = 0; p < 16; p++) begin
            for (int w = 0; w < 16; w++) begin
                for (int e = 0; e < 16; e++) begin
                    load(4'(p));
                    reg_wr = 1; reg_sel = 0; wdata = {4'hF, 4'(w)}; evt = 4'(e);
                    tick(); idle();
                    chk(flags == 4'((p & w) | e), "R7", flags, (p & w) | e);
                end
            end
        end

        // R11 fail kept by status read/write, cleared by RTC write
        set_auto(1);
        stat_rd = 1; tick(); idle();
        reg_wr = 1; reg_sel = 0; wdata = 8'h00; tick(); idle();
        chk(clk_fail == 1, "R11", clk_fail, 1);
        rtc_wr = 1; tick(); idle();
        chk(clk_fail == 0, "R11", clk_fail, 0);

        // R10 single supply losses
        main_ok = 0; wait_fail(0, "R10");
        main_ok = 1; wait_fail(0, "R10");
        bat_ok = 0;  wait_fail(0, "R10");
        bat_ok = 1;  wait_fail(0, "R10");
        main_ok = 0; wait_fail(0, "R10");
        bat_ok = 1;  main_ok = 1; wait_fail(0, "R10");

        // R9 total loss, main returns first
        main_ok = 0; bat_ok = 0; wait_fail(0, "R9");
        main_ok = 1; wait_fail(1, "R9");
        bat_ok = 1;
        rtc_wr = 1; tick(); idle();
        chk(clk_fail == 0, "R11", clk_fail, 0);

        // R9 staggered loss, battery returns first
        bat_ok = 0; tick(); main_ok = 0; wait_fail(0, "R9");
        bat_ok = 1; wait_fail(1, "R9");
        main_ok = 1;
        rtc_wr = 1; tick(); idle();
        wait_fail(0, "R11");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule